// File: doc/BRIEF.md
# Two/Three-Level Modulation Level Selector

This block decides, once per PWM period, whether a three-phase inverter modulator should produce a two-level or a three-level space-vector pattern. It looks at the commanded electrical drive frequency, which is an unsigned fixed-point value with four fractional bits (Q8.4 by default, so 10 Hz reads as 160). It compares that value with a threshold input. A small hysteresis band above the threshold stops the mode from toggling when the frequency sits close to the threshold.

The selector also sets the drive's life cycle. A run request starts the drive in two-level mode for a fixed number of PWM periods. Level selection by frequency then takes over. A stop request is latched. At the next period boundary it forces two-level mode. The enable stays high for a fixed number of ramp-down periods, and then the gate encoder is told to shut down. A device-fault flag reports a shorted device in one of the parallel groups. While it is high, the level in use is frozen and the bridge keeps running. Every change of level or state takes effect only at a period boundary, so no single period mixes the two patterns.

Top module: `level_mode_sel`

## Requirements
- R1: While reset is asserted and just after it is released, shutdown_o is 1, mod_en_o is 0 and level3_o is 0 (two-level).
- R2: In the idle state, a boundary with run_i=1 and stop_i=0 sets mod_en_o=1 and shutdown_o=0 with level3_o=0. The level stays two-level for that boundary and the next START_PERIODS boundaries, whatever the frequency.
- R3: In running operation, a boundary moves the level from two-level to three-level only when freq_i > thr_i + HYST. Both are compared as unsigned values of the same fixed-point format, without overflow.
- R4: In running operation with fault_i=0, a boundary with freq_i <= thr_i gives level3_o=0. At thr_i < freq_i <= thr_i + HYST, the level in use is kept.
- R5: level3_o changes only in the cycle after a cycle with period_end_i=1.
- R6: A boundary with fault_i=1 and no stop request leaves level3_o unchanged and keeps mod_en_o=1 and shutdown_o=0, at any frequency.
- R7: A one-cycle stop_i pulse while enabled is remembered. At the next boundary level3_o goes to 0 while mod_en_o stays 1. After RAMP_PERIODS further boundaries, shutdown_o=1 and mod_en_o=0. This also applies when stop arrives during start-up.
- R8: mod_en_o is always the inverse of shutdown_o, and level3_o=1 only while mod_en_o=1.
- R9: With the default threshold of 10 Hz (160), 6.1 Hz (98) runs in two-level mode and 48.8 Hz (781) runs in three-level mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| freq_i | input | FREQ_W | Commanded drive frequency, unsigned, FRAC_W fractional bits |
| thr_i | input | FREQ_W | Two/three-level threshold, same format as freq_i |
| period_end_i | input | 1 | One-cycle strobe at the end of each PWM period |
| run_i | input | 1 | Run request |
| stop_i | input | 1 | Stop request, pulse or level |
| fault_i | input | 1 | A device in a parallel group is shorted |
| level3_o | output | 1 | 1 = three-level modulation, 0 = two-level |
| mod_en_o | output | 1 | Modulator enable |
| shutdown_o | output | 1 | Shutdown request to the gate encoder |

## Verification
The assertions assume that period_end_i is a strobe sampled at clock edges, and that freq_i and thr_i are valid unsigned values at each boundary. They do not assume the inputs are stable between boundaries. The bench therefore changes freq_i and the control inputs freely between strobes, including away from boundaries, and only asserts the strobe for one cycle at a time. The frequency sweeps run up and down across the threshold and the hysteresis band, once with the default threshold and once with a moved one. Every step is compared with a level model kept in the bench.

// File: rtl/lms_pkg.sv
package lms_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_RUN   = 2'd2,
    ST_RAMP  = 2'd3
  } lms_state_e;
endpackage

// File: rtl/lms_cmp.sv
module lms_cmp #(
  parameter int FREQ_W = 12,
  parameter int HYST   = 8
) (
  input  logic [FREQ_W-1:0] freq_i,
  input  logic [FREQ_W-1:0] thr_i,
  input  logic              cur_lvl_i,
  output logic              next_lvl_o
);
  localparam int UP_W = FREQ_W + 1;

  logic [UP_W-1:0] up_lim;
  logic [UP_W-1:0] freq_x;

  assign up_lim = {1'b0, thr_i} + UP_W'(HYST);
  assign freq_x = {1'b0, freq_i};

  // rise above thr+HYST, fall at or below thr
  always_comb begin
    if (cur_lvl_i) next_lvl_o = (freq_i > thr_i);
    else           next_lvl_o = (freq_x > up_lim);
  end
endmodule

// File: rtl/lms_prd_cnt.sv
module lms_prd_cnt #(
  parameter int LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  assign done_o = tick_i && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= done_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/lms_seq.sv
module lms_seq
  import lms_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       period_end_i,
  input  logic       run_i,
  input  logic       stop_i,
  input  logic       fault_i,
  input  logic       lvl_req_i,
  input  logic       start_done_i,
  input  logic       ramp_done_i,
  output lms_state_e state_o,
  output logic       level3_o,
  output logic       stop_pend_o
);
  lms_state_e state_q;
  logic       lvl_q;
  logic       stop_pend_q;
  logic       stop_any;

  assign stop_any = stop_pend_q | stop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      lvl_q       <= 1'b0;
      stop_pend_q <= 1'b0;
    end else begin
      if (state_q != ST_IDLE && stop_i) stop_pend_q <= 1'b1;
      case (state_q)
        ST_IDLE: begin
          stop_pend_q <= 1'b0;
          lvl_q       <= 1'b0;
          if (period_end_i && run_i && !stop_i) state_q <= ST_START;
        end
        ST_START: begin
          if (period_end_i) begin
            if (stop_any) begin
              state_q     <= ST_RAMP;
              stop_pend_q <= 1'b0;
            end else if (start_done_i) begin
              state_q <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (period_end_i) begin
            if (stop_any) begin
              lvl_q       <= 1'b0;
              state_q     <= ST_RAMP;
              stop_pend_q <= 1'b0;
            end else if (!fault_i) begin
              lvl_q <= lvl_req_i;
            end
          end
        end
        ST_RAMP: begin
          stop_pend_q <= 1'b0;
          lvl_q       <= 1'b0;
          if (period_end_i && ramp_done_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o     = state_q;
  assign level3_o    = lvl_q;
  assign stop_pend_o = stop_pend_q;
endmodule

// File: rtl/level_mode_sel.sv
module level_mode_sel
  import lms_pkg::*;
#(
  parameter int FREQ_W        = 12,
  parameter int FRAC_W        = 4,
  parameter int HYST          = 8,
  parameter int START_PERIODS = 4,
  parameter int RAMP_PERIODS  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FREQ_W-1:0] freq_i,
  input  logic [FREQ_W-1:0] thr_i,
  input  logic              period_end_i,
  input  logic              run_i,
  input  logic              stop_i,
  input  logic              fault_i,
  output logic              level3_o,
  output logic              mod_en_o,
  output logic              shutdown_o
);
  localparam int NPH = 2;  // phase counters: start-up, ramp-down
  localparam int FRAC_CHK = (FRAC_W < FREQ_W) ? 1 : 0;

  lms_state_e state;
  logic       lvl_cur;
  logic       lvl_req;
  logic       stop_pend;
  logic [NPH-1:0] ph_done;
  logic [NPH-1:0] ph_act;

  if (FRAC_CHK == 0) begin : g_bad_fmt
    initial $error("FRAC_W must be below FREQ_W");
  end

  assign ph_act[0] = (state == ST_START);
  assign ph_act[1] = (state == ST_RAMP);

  for (genvar g = 0; g < NPH; g++) begin : g_ph
    localparam int LIM = (g == 0) ? START_PERIODS : RAMP_PERIODS;
    lms_prd_cnt #(.LIMIT(LIM)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (!ph_act[g]),
      .tick_i (period_end_i && ph_act[g]),
      .done_o (ph_done[g])
    );
  end

  lms_cmp #(.FREQ_W(FREQ_W), .HYST(HYST)) u_cmp (
    .freq_i     (freq_i),
    .thr_i      (thr_i),
    .cur_lvl_i  (lvl_cur),
    .next_lvl_o (lvl_req)
  );

  lms_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .period_end_i (period_end_i),
    .run_i        (run_i),
    .stop_i       (stop_i),
    .fault_i      (fault_i),
    .lvl_req_i    (lvl_req),
    .start_done_i (ph_done[0]),
    .ramp_done_i  (ph_done[1]),
    .state_o      (state),
    .level3_o     (lvl_cur),
    .stop_pend_o  (stop_pend)
  );

  assign level3_o   = lvl_cur;
  assign mod_en_o   = (state != ST_IDLE);
  assign shutdown_o = (state == ST_IDLE);
endmodule

// File: rtl/lms_chk.sv
module lms_chk #(
  parameter int FREQ_W = 12,
  parameter int HYST   = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [FREQ_W-1:0] freq_i,
  input logic [FREQ_W-1:0] thr_i,
  input logic              period_end_i,
  input logic              stop_i,
  input logic              fault_i,
  input logic              stop_pend,
  input logic              level3_o,
  input logic              mod_en_o,
  input logic              shutdown_o
);
  localparam int UP_W = FREQ_W + 1;
  logic [UP_W-1:0] up_lim;
  logic [UP_W-1:0] freq_x;
  assign up_lim = {1'b0, thr_i} + UP_W'(HYST);
  assign freq_x = {1'b0, freq_i};

  // R8
  en_shdn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_en_o != shutdown_o);

  // R8
  lvl_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level3_o |-> mod_en_o);

  // R5
  lvl_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !period_end_i |=> $stable(level3_o));

  // R3
  lvl_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(level3_o) |-> ($past(period_end_i) && ($past(freq_x) > $past(up_lim))));

  // R4
  lvl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_end_i && !fault_i && (freq_i <= thr_i)) |=> !level3_o);

  // R6
  fault_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_end_i && fault_i && !stop_i && !stop_pend) |=> $stable(level3_o));

  // R7
  shdn_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shutdown_o) |-> ($past(period_end_i) && !$past(level3_o)));
endmodule

bind level_mode_sel lms_chk #(.FREQ_W(FREQ_W), .HYST(HYST)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .freq_i       (freq_i),
  .thr_i        (thr_i),
  .period_end_i (period_end_i),
  .stop_i       (stop_i),
  .fault_i      (fault_i),
  .stop_pend    (stop_pend),
  .level3_o     (level3_o),
  .mod_en_o     (mod_en_o),
  .shutdown_o   (shutdown_o)
);

// File: tb/level_mode_sel_tb.sv
module level_mode_sel_tb;
  localparam int FREQ_W = 12;
  localparam int HYST   = 8;
  localparam int NST    = 4;
  localparam int NRP    = 4;
  localparam int THR0   = 160;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [FREQ_W-1:0] freq = '0;
  logic [FREQ_W-1:0] thr = FREQ_W'(THR0);
  logic pe = 1'b0, run = 1'b0, stop = 1'b0, fault = 1'b0;
  logic lvl3, en, shdn;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  level_mode_sel #(
    .FREQ_W(FREQ_W), .FRAC_W(4), .HYST(HYST),
    .START_PERIODS(NST), .RAMP_PERIODS(NRP)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .freq_i(freq), .thr_i(thr),
    .period_end_i(pe), .run_i(run), .stop_i(stop), .fault_i(fault),
    .level3_o(lvl3), .mod_en_o(en), .shutdown_o(shdn)
  );

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic bnd();
    @(negedge clk) pe = 1'b1;
    @(negedge clk) pe = 1'b0;
  endtask

  task automatic chk_all(string tag, logic e_l, logic e_en);
    chk({tag, " level"}, lvl3, e_l);
    chk({tag, " en"}, en, e_en);
    chk({tag, " shdn"}, shdn, !e_en);
  endtask

  // bench level model for running operation
  function automatic logic model(logic cur, int f, int t);
    if (cur) return (f > t);
    return (f > t + HYST);
  endfunction

  task automatic start_drive(int f);
    freq = FREQ_W'(f);
    run = 1'b1;
    bnd();
    for (int i = 0; i < NST; i++) bnd();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic exp;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk_all("R1 in reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 after reset", 1'b0, 1'b0);

    // R2 start-up stays two-level even at high frequency
    freq = FREQ_W'(781);
    run = 1'b1;
    bnd();
    chk_all("R2 start", 1'b0, 1'b1);
    for (int i = 0; i < NST; i++) begin
      bnd();
      chk_all("R2 start hold", 1'b0, 1'b1);
    end

    // R9 operating points
    freq = FREQ_W'(98);
    bnd();
    chk_all("R9 6.1Hz", 1'b0, 1'b1);
    freq = FREQ_W'(781);
    bnd();
    chk_all("R9 48.8Hz", 1'b1, 1'b1);

    // R5 no change away from boundaries
    freq = '0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R5 no boundary", lvl3, 1'b1);
    end
    bnd();
    chk("R4 drop at 0", lvl3, 1'b0);

    // R3 R4 sweeps, two thresholds
    exp = 1'b0;
    for (int pass = 0; pass < 2; pass++) begin
      int t;
      t = (pass == 0) ? THR0 : 300;
      thr = FREQ_W'(t);
      for (int f = t - 20; f <= t + 20; f++) begin
        freq = FREQ_W'(f);
        bnd();
        exp = model(exp, f, t);
        chk("R3 sweep up", lvl3, exp);
      end
      for (int f = t + 20; f >= t - 20; f--) begin
        freq = FREQ_W'(f);
        bnd();
        exp = model(exp, f, t);
        chk("R4 sweep down", lvl3, exp);
      end
    end
    // R3 threshold near top of range, no overflow
    thr = FREQ_W'(4090);
    freq = FREQ_W'(4095);
    bnd();
    chk("R3 no overflow", lvl3, 1'b0);
    thr = FREQ_W'(THR0);

    // R6 fault freezes level
    freq = FREQ_W'(781);
    bnd();
    chk("R6 pre", lvl3, 1'b1);
    fault = 1'b1;
    freq = '0;
    bnd();
    chk_all("R6 fault hold 3L", 1'b1, 1'b1);
    fault = 1'b0;
    bnd();
    chk("R6 release", lvl3, 1'b0);
    fault = 1'b1;
    freq = FREQ_W'(781);
    bnd();
    chk_all("R6 fault hold 2L", 1'b0, 1'b1);
    fault = 1'b0;
    bnd();
    chk("R6 release up", lvl3, 1'b1);

    // R7 stop from three-level
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    run = 1'b0;
    chk_all("R7 latched", 1'b1, 1'b1);
    bnd();
    chk_all("R7 forced 2L", 1'b0, 1'b1);
    for (int i = 0; i < NRP - 1; i++) begin
      bnd();
      chk_all("R7 ramp", 1'b0, 1'b1);
    end
    bnd();
    chk_all("R7 shutdown", 1'b0, 1'b0);
    bnd();
    chk_all("R7 idle stays", 1'b0, 1'b0);

    // R7 stop during start-up
    freq = FREQ_W'(781);
    run = 1'b1;
    bnd();
    chk_all("R2 restart", 1'b0, 1'b1);
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
    run = 1'b0;
    bnd();
    chk_all("R7 start stop", 1'b0, 1'b1);
    for (int i = 0; i < NRP - 1; i++) begin
      bnd();
      chk_all("R7 start ramp", 1'b0, 1'b1);
    end
    bnd();
    chk_all("R7 start shutdown", 1'b0, 1'b0);

    // R1 reset mid-run
    start_drive(781);
    bnd();
    chk("R9 run again", lvl3, 1'b1);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk_all("R1 reset mid-run", 1'b0, 1'b0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule